// File: doc/BRIEF.md
# SIMD Immediate-Shift Decode and Execute Unit

This unit accepts a 32-bit vector shift-by-immediate instruction word together with a 128-bit source operand. From that word it works out the operation, the lane size and the effective shift amount. It then shifts every lane of the operand and presents the result one clock later. The supported shifts are arithmetic right, logical right and left.

The lane size is not held in a dedicated field. It follows from where the highest set bit sits in the 6-bit immediate field, unless a separate long bit forces 64-bit lanes. Right-shift amounts are stored as the lane width minus the field value, so a right shift can span the whole lane. When it does, the lane saturates instead of wrapping: a signed shift fills the lane with its sign bit, and an unsigned shift clears it.

Encodings that do not belong to this class raise an undefined flag and return a zero result. The destination and source register indices held in the word are decoded and passed through next to the result, so the surrounding pipeline can route them.

Top module: `vshift_imm_unit`

## Requirements
- R1: A word belongs to the class only when bits 31:25 equal 1111001, bit 23 is 1 and bit 4 is 1. Any other word sets the undefined flag.
- R2: Bits 11:8 select the operation, and bit 24 is the unsigned flag. 0000 with bit 24 = 0 is an arithmetic right shift. 0000 with bit 24 = 1 is a logical right shift. 0101 with bit 24 = 0 is a left shift. Every other combination, including 0101 with bit 24 = 1, sets the undefined flag.
- R3: With bit 7 = 1 the lanes are 64 bits wide and the raw amount is bits 21:16. With bit 7 = 0 the lane size comes from the highest set bit of bits 21:16. Bit 21 gives 32-bit lanes with raw amount bits 20:16. Bit 20 gives 16-bit lanes with raw amount bits 19:16. Bit 19 gives 8-bit lanes with raw amount bits 18:16. If bits 21:19 are all zero, the undefined flag is set.
- R4: For a right shift, the effective amount is the lane width minus the raw amount, which lies in the range 1 to the lane width.
- R5: For a left shift, the effective amount is the raw amount, and bits shifted in are zero.
- R6: An arithmetic right shift by the full lane width produces a lane in which every bit equals that lane's sign bit.
- R7: A logical right shift by the full lane width produces an all-zero lane.
- R8: Bit 6 = 1 processes all 128 bits. Bit 6 = 0 processes only the low 64 bits and forces result bits 127:64 to zero.
- R9: When the undefined flag is set, the result is all zeros.
- R10: The destination index output equals {bit 22, bits 15:12}, and the source index output equals {bit 5, bits 3:0}.
- R11: The valid output follows the input strobe exactly one cycle later. A synchronous active-high reset clears the valid flag, the undefined flag, the result and the indices.
- R12: While the input strobe is low, the result, the undefined flag and the indices hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| in_insn | input | 32 | Shift-by-immediate instruction word |
| in_src | input | 128 | Source vector operand |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_undef | output | 1 | Encoding is not a supported shift |
| out_result | output | 128 | Shifted vector |
| out_rd | output | 5 | Decoded destination register index |
| out_rm | output | 5 | Decoded source register index |

## Verification
The bench builds the unit with its default vector width of 128. That width is the only one the half-width select supports, and with it all four lane sizes and both halves of the result can be reached. A bit-level reference model in the bench drives each lane size through amounts of zero, one, mid-range, width minus one and full width. This covers the saturation corners of right shifts in both signednesses. The bench also steps through each illegal-encoding path and the hold behaviour between strobes.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

    localparam int VEC_BITS  = 128;
    localparam int AMT_BITS  = 7;
    localparam int IDX_BITS  = 5;
    localparam int INSN_BITS = 32;

    typedef enum logic [1:0] {
        LANE_B = 2'd0,
        LANE_H = 2'd1,
        LANE_S = 2'd2,
        LANE_D = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        SH_RIGHT_S = 2'd0,
        SH_RIGHT_U = 2'd1,
        SH_LEFT    = 2'd2
    } shop_e;

    typedef struct packed {
        logic                undef;
        shop_e               op;
        lane_e               lane;
        logic [AMT_BITS-1:0] amt;
        logic                full;
        logic [IDX_BITS-1:0] rd;
        logic [IDX_BITS-1:0] rm;
    } dec_t;

endpackage

// File: rtl/vshift_decode.sv
module vshift_decode
    import vshift_pkg::*;
(
    input  logic [INSN_BITS-1:0] insn,
    output dec_t                 dec
);

    localparam logic [6:0] CLASS_TAG = 7'b1111001;
    localparam logic [3:0] OPC_RIGHT = 4'b0000;
    localparam logic [3:0] OPC_LEFT  = 4'b0101;

    logic                fixed_ok;
    logic                uns;
    logic [3:0]          opc;
    logic                is_long;
    logic [5:0]          imm;
    logic                size_bad;
    logic                op_bad;
    logic [AMT_BITS-1:0] raw_amt;
    logic [AMT_BITS-1:0] lane_bits;
    lane_e               lane;
    shop_e               op;

    always_comb begin
        fixed_ok = (insn[31:25] == CLASS_TAG) && insn[23] && insn[4];
        uns      = insn[24];
        opc      = insn[11:8];
        is_long  = insn[7];
        imm      = insn[21:16];
    end

    // Lane size from the long bit or the leading one of the immediate field
    always_comb begin
        size_bad  = 1'b0;
        lane      = LANE_D;
        raw_amt   = '0;
        lane_bits = AMT_BITS'(64);
        if (is_long) begin
            lane      = LANE_D;
            raw_amt   = {1'b0, imm};
            lane_bits = AMT_BITS'(64);
        end else if (imm[5]) begin
            lane      = LANE_S;
            raw_amt   = {2'b00, imm[4:0]};
            lane_bits = AMT_BITS'(32);
        end else if (imm[4]) begin
            lane      = LANE_H;
            raw_amt   = {3'b000, imm[3:0]};
            lane_bits = AMT_BITS'(16);
        end else if (imm[3]) begin
            lane      = LANE_B;
            raw_amt   = {4'b0000, imm[2:0]};
            lane_bits = AMT_BITS'(8);
        end else begin
            size_bad  = 1'b1;
        end
    end

    // Operation select
    always_comb begin
        op     = SH_RIGHT_S;
        op_bad = 1'b0;
        if (opc == OPC_RIGHT) begin
            op = uns ? SH_RIGHT_U : SH_RIGHT_S;
        end else if (opc == OPC_LEFT && !uns) begin
            op = SH_LEFT;
        end else begin
            op_bad = 1'b1;
        end
    end

    always_comb begin
        dec.undef = !fixed_ok || size_bad || op_bad;
        dec.op    = op;
        dec.lane  = lane;
        dec.amt   = (op == SH_LEFT) ? raw_amt : (lane_bits - raw_amt);
        dec.full  = insn[6];
        dec.rd    = {insn[22], insn[15:12]};
        dec.rm    = {insn[5], insn[3:0]};
    end

endmodule

// File: rtl/vshift_lane.sv
module vshift_lane
    import vshift_pkg::*;
#(
    parameter int W     = 8,
    parameter int AMT_W = AMT_BITS
) (
    input  logic [W-1:0]     x,
    input  shop_e            op,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     y
);

    localparam logic [AMT_W-1:0] WIDTH_A = AMT_W'(W);
    localparam logic [AMT_W-1:0] TOP_A   = AMT_W'(W - 1);

    logic              over;
    logic [AMT_W-1:0]  amt_sat;

    always_comb begin
        over    = (amt >= WIDTH_A);
        amt_sat = over ? TOP_A : amt;
        unique case (op)
            SH_RIGHT_S: y = W'($signed(x) >>> amt_sat);
            SH_RIGHT_U: y = over ? '0 : (x >> amt);
            SH_LEFT:    y = over ? '0 : (x << amt);
            default:    y = '0;
        endcase
    end

endmodule

// File: rtl/vshift_datapath.sv
module vshift_datapath
    import vshift_pkg::*;
#(
    parameter int VEC_W = VEC_BITS,
    parameter int AMT_W = AMT_BITS
) (
    input  logic [VEC_W-1:0] src,
    input  shop_e            op,
    input  lane_e            lane,
    input  logic [AMT_W-1:0] amt,
    input  logic             full,
    output logic [VEC_W-1:0] res
);

    localparam int N_SIZES = 4;
    localparam int HALF    = VEC_W / 2;

    logic [VEC_W-1:0] by_size [N_SIZES];
    logic [VEC_W-1:0] picked;

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        localparam int LW = 8 << s;
        localparam int NL = VEC_W / LW;
        logic [VEC_W-1:0] r;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            vshift_lane #(
                .W     (LW),
                .AMT_W (AMT_W)
            ) u_lane (
                .x   (src[l*LW +: LW]),
                .op  (op),
                .amt (amt),
                .y   (r[l*LW +: LW])
            );
        end
        assign by_size[s] = r;
    end

    always_comb begin
        picked = by_size[lane];
        res    = full ? picked : {{HALF{1'b0}}, picked[HALF-1:0]};
    end

endmodule

// File: rtl/vshift_imm_unit.sv
module vshift_imm_unit
    import vshift_pkg::*;
#(
    parameter int VEC_W = VEC_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSN_BITS-1:0] in_insn,
    input  logic [VEC_W-1:0]     in_src,
    output logic                 out_valid,
    output logic                 out_undef,
    output logic [VEC_W-1:0]     out_result,
    output logic [IDX_BITS-1:0]  out_rd,
    output logic [IDX_BITS-1:0]  out_rm
);

    typedef struct packed {
        logic                valid;
        logic                undef;
        logic [VEC_W-1:0]    result;
        logic [IDX_BITS-1:0] rd;
        logic [IDX_BITS-1:0] rm;
    } stage_t;

    dec_t             dec;
    logic [VEC_W-1:0] dp_res;
    stage_t           st_d;
    stage_t           st_q;

    vshift_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    vshift_datapath #(
        .VEC_W (VEC_W),
        .AMT_W (AMT_BITS)
    ) u_dp (
        .src  (in_src),
        .op   (dec.op),
        .lane (dec.lane),
        .amt  (dec.amt),
        .full (dec.full),
        .res  (dp_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.undef  = dec.undef;
            st_d.result = dec.undef ? '0 : dp_res;
            st_d.rd     = dec.rd;
            st_d.rm     = dec.rm;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_undef  = st_q.undef;
    assign out_result = st_q.result;
    assign out_rd     = st_q.rd;
    assign out_rm     = st_q.rm;

endmodule

// File: rtl/vshift_imm_unit_chk.sv
module vshift_imm_unit_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [31:0]      in_insn,
    input logic             out_valid,
    input logic             out_undef,
    input logic [VEC_W-1:0] out_result,
    input logic [4:0]       out_rd,
    input logic [4:0]       out_rm
);

    localparam int HALF = VEC_W / 2;

    p_strobe_set_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_strobe_clr_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_undef_zero_r9: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> (out_result == '0));

    p_half_upper_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_insn[6]) |=> (out_result[VEC_W-1:HALF] == '0));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_undef)
                       && $stable(out_rd) && $stable(out_rm)));

    p_regidx_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_rd == $past({in_insn[22], in_insn[15:12]})
                      && out_rm == $past({in_insn[5], in_insn[3:0]})));

    p_badop_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn[11:8] != 4'b0000 && in_insn[11:8] != 4'b0101)
        |=> out_undef);

    p_fixed_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_insn[31:25] != 7'b1111001 || !in_insn[23] || !in_insn[4]))
        |=> out_undef);

    p_usat_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn[31:23] == 9'b111100111 && in_insn[4]
         && in_insn[11:8] == 4'b0000 && in_insn[7] && in_insn[21:16] == 6'd0)
        |=> (out_result == '0 && !out_undef));

endmodule

bind vshift_imm_unit vshift_imm_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_insn    (in_insn),
    .out_valid  (out_valid),
    .out_undef  (out_undef),
    .out_result (out_result),
    .out_rd     (out_rd),
    .out_rm     (out_rm)
);

// File: tb/sim_vshift_imm_unit.sv
module sim_vshift_imm_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  in_insn;
    logic [127:0] in_src;
    logic         out_valid;
    logic         out_undef;
    logic [127:0] out_result;
    logic [4:0]   out_rd;
    logic [4:0]   out_rm;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [127:0] PAT_A = 128'h8123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
    localparam logic [127:0] PAT_B = 128'h7F80_00FF_C3A5_5A3C_0123_8000_FFFF_7001;

    always #2 clk = ~clk;

    vshift_imm_unit u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_insn    (in_insn),
        .in_src     (in_src),
        .out_valid  (out_valid),
        .out_undef  (out_undef),
        .out_result (out_result),
        .out_rd     (out_rd),
        .out_rm     (out_rm)
    );

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_insn(bit uns, logic [3:0] opc, bit lng,
                                            logic [5:0] imm, bit q,
                                            logic [4:0] vd, logic [4:0] vm);
        return {7'b1111001, uns, 1'b1, vd[4], imm, vd[3:0], opc,
                lng, q, vm[4], 1'b1, vm[3:0]};
    endfunction

    // {long, imm6} for a lane width and raw field value
    function automatic logic [6:0] enc_imm(int lw, int raw);
        case (lw)
            8:       return {1'b0, 3'b001, raw[2:0]};
            16:      return {1'b0, 2'b01, raw[3:0]};
            32:      return {1'b0, 1'b1, raw[4:0]};
            default: return {1'b1, raw[5:0]};
        endcase
    endfunction

    // kind: 0 arithmetic right, 1 logical right, 2 left
    function automatic logic [127:0] ref_shift(int kind, int lw, int amt, bit q,
                                               logic [127:0] src);
        logic [127:0] r = '0;
        for (int l = 0; l < 128 / lw; l++) begin
            for (int b = 0; b < lw; b++) begin
                int j;
                logic bv;
                if (kind == 2) begin
                    j  = b - amt;
                    bv = (j >= 0) ? src[l*lw + j] : 1'b0;
                end else begin
                    j = b + amt;
                    if (j < lw) bv = src[l*lw + j];
                    else        bv = (kind == 0) ? src[l*lw + lw - 1] : 1'b0;
                end
                r[l*lw + b] = bv;
            end
        end
        if (!q) r[127:64] = '0;
        return r;
    endfunction

    task automatic issue(logic [31:0] insn, logic [127:0] src);
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = insn;
        in_src   = src;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_shift(string req, int kind, int lw, int amt, bit q,
                             logic [127:0] src);
        int         raw;
        logic [6:0] e;
        raw = (kind == 2) ? amt : lw - amt;
        e   = enc_imm(lw, raw);
        issue(mk_insn(kind == 1, (kind == 2) ? 4'b0101 : 4'b0000, e[6], e[5:0], q,
                      5'd3, 5'd17), src);
        chk(req, out_result, ref_shift(kind, lw, amt, q, src));
        chk({req, " valid"}, {127'd0, out_valid}, 128'd1);
        chk({req, " undef"}, {127'd0, out_undef}, 128'd0);
    endtask

    task automatic t_reset;
        rst      = 1'b1;
        in_valid = 1'b0;
        in_insn  = '0;
        in_src   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset valid",  {127'd0, out_valid}, 128'd0);
        chk("R11 reset result", out_result, 128'd0);
        chk("R11 reset undef",  {127'd0, out_undef}, 128'd0);
    endtask

    task automatic t_sshr;
        for (int s = 0; s < 4; s++) begin
            int lw = 8 << s;
            run_shift("R4 R3 sshr by 1", 0, lw, 1, 1'b1, PAT_A);
            run_shift("R4 sshr mid",     0, lw, lw / 2 - 1, 1'b1, PAT_B);
            run_shift("R6 sshr full",    0, lw, lw, 1'b1, PAT_A);
            run_shift("R6 sshr full b",  0, lw, lw, 1'b1, PAT_B);
        end
    endtask

    task automatic t_ushr;
        for (int s = 0; s < 4; s++) begin
            int lw = 8 << s;
            run_shift("R4 ushr by 1",  1, lw, 1, 1'b1, PAT_A);
            run_shift("R4 ushr wm1",   1, lw, lw - 1, 1'b1, PAT_B);
            run_shift("R7 ushr full",  1, lw, lw, 1'b1, PAT_A);
        end
    endtask

    task automatic t_shl;
        for (int s = 0; s < 4; s++) begin
            int lw = 8 << s;
            run_shift("R5 shl by 0",   2, lw, 0, 1'b1, PAT_A);
            run_shift("R5 shl by 3",   2, lw, 3, 1'b1, PAT_B);
            run_shift("R5 shl wm1",    2, lw, lw - 1, 1'b1, PAT_A);
        end
    endtask

    task automatic t_half;
        run_shift("R8 half sshr 16", 0, 16, 5, 1'b0, PAT_A);
        run_shift("R8 half ushr 64", 1, 64, 7, 1'b0, PAT_A);
        run_shift("R8 half shl 8",   2, 8, 2, 1'b0, PAT_B);
        run_shift("R8 half sshr 32", 0, 32, 32, 1'b0, PAT_B);
    endtask

    task automatic t_undef_one(string req, logic [31:0] insn);
        issue(insn, PAT_A);
        chk({req, " flag"},   {127'd0, out_undef}, 128'd1);
        chk({req, " R9 zero"}, out_result, 128'd0);
        chk({req, " valid"},  {127'd0, out_valid}, 128'd1);
    endtask

    task automatic t_undef;
        logic [31:0] good;
        good = mk_insn(1'b0, 4'b0000, 1'b0, 6'b100011, 1'b1, 5'd1, 5'd2);
        t_undef_one("R2 opcode 0001", mk_insn(1'b0, 4'b0001, 1'b0, 6'b100011, 1'b1, 5'd1, 5'd2));
        t_undef_one("R2 left uns",    mk_insn(1'b1, 4'b0101, 1'b0, 6'b100011, 1'b1, 5'd1, 5'd2));
        t_undef_one("R3 size 000",    mk_insn(1'b0, 4'b0000, 1'b0, 6'b000111, 1'b1, 5'd1, 5'd2));
        t_undef_one("R1 bit31",       good & ~32'h8000_0000);
        t_undef_one("R1 bit23",       good & ~32'h0080_0000);
        t_undef_one("R1 bit4",        good & ~32'h0000_0010);
        run_shift("R3 long wins over size bits", 1, 64, 64, 1'b1, PAT_B);
    endtask

    task automatic t_regidx;
        issue(mk_insn(1'b0, 4'b0101, 1'b0, 6'b001001, 1'b1, 5'b10110, 5'b01001), PAT_A);
        chk("R10 rd a", {123'd0, out_rd}, {123'd0, 5'b10110});
        chk("R10 rm a", {123'd0, out_rm}, {123'd0, 5'b01001});
        issue(mk_insn(1'b1, 4'b0000, 1'b1, 6'b000010, 1'b0, 5'b01001, 5'b11110), PAT_B);
        chk("R10 rd b", {123'd0, out_rd}, {123'd0, 5'b01001});
        chk("R10 rm b", {123'd0, out_rm}, {123'd0, 5'b11110});
    endtask

    task automatic t_hold;
        logic [127:0] exp;
        exp = ref_shift(0, 8, 2, 1'b1, PAT_B);
        issue(mk_insn(1'b0, 4'b0000, 1'b0, 6'b001110, 1'b1, 5'd7, 5'd9), PAT_B);
        chk("R12 hold first", out_result, exp);
        in_insn = mk_insn(1'b0, 4'b0001, 1'b0, 6'b000000, 1'b1, 5'd30, 5'd31);
        in_src  = PAT_A;
        repeat (3) @(negedge clk);
        chk("R11 valid drops",  {127'd0, out_valid}, 128'd0);
        chk("R12 result held",  out_result, exp);
        chk("R12 undef held",   {127'd0, out_undef}, 128'd0);
        chk("R12 rd held",      {123'd0, out_rd}, {123'd0, 5'd7});
        chk("R12 rm held",      {123'd0, out_rm}, {123'd0, 5'd9});
    endtask

    initial begin
        t_reset();
        t_sshr();
        t_ushr();
        t_shl();
        t_half();
        t_undef();
        t_regidx();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R11: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule